// File: doc/BRIEF.md
# Iterative Bit Gather/Scatter Unit

This unit moves bits between a 32-bit source word and positions chosen by a 32-bit mask word. In gather mode it collects the source bits that sit under the set mask bits and packs them, in ascending order, into the low end of the result. In scatter mode it does the reverse: it takes the low-order source bits in ascending order and places them at the positions of the set mask bits. No status flags are produced.

A caller drives the operands and the mode, then pulses `start` while the unit is idle. The unit then examines one mask position per clock, from bit 0 upward. It stops as soon as the part of the mask not yet examined holds no set bit. It then pulses `done` for one cycle and holds the result until the next accepted start. Because the run stops early, the latency depends only on the highest set mask bit, and a sparse low mask finishes quickly.

Top module: `bxd_unit`

## Requirements
- R1: With `op`=0 (gather), result bit k equals the source bit at the position of the k-th set mask bit, counting set bits from 0 starting at mask bit 0.
- R2: With `op`=1 (scatter), for each set mask bit at position p that is the k-th set bit counting from 0, result bit p equals source bit k.
- R3: Every result bit that is not written is zero. In gather, bits at and above the mask popcount are zero. In scatter, bits where the mask is 0 are zero.
- R4: For a nonzero mask whose highest set bit is h, `done` is high exactly h+2 clock edges after the edge that accepted the start, counting that edge as 0.
- R5: An all-zero mask gives `done` one edge after the accepting edge, with a zero result.
- R6: A `start` pulse while `busy` is high is ignored. The operation in progress completes with its original operands.
- R7: `done` is high for exactly one cycle, and `busy` is low while it is high. While idle without a start, the result stays stable whatever the operand and mode inputs do.
- R8: A start accepted while idle raises `busy` and clears the result to zero on the accepting edge.
- R9: Synchronous active-high `rst` makes `busy`=0, `done`=0 and `result`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation when idle |
| op | input | 1 | 0 = gather, 1 = scatter |
| src | input | 32 | Source operand |
| mask | input | 32 | Selection mask |
| result | output | 32 | Operation result |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Operation in progress |

## Verification
The bench goes after the mask shapes that separate the two pointer rules. It uses an all-zero mask, an all-ones mask, a lone top bit, a lone bottom bit, alternating masks and sparse random masks, in both modes. A design that advanced the wrong pointer on clear mask bits would show swapped or shifted bits in scatter results. A design that ran a fixed 32 steps, or stopped one step early, would miss the exact latency checks tied to the highest set bit. A start pulse injected mid-run catches a unit that reloads while busy. Idle cycles with changing inputs catch a result register that is not held.

// File: rtl/bxd_pkg.sv
package bxd_pkg;

  typedef enum logic {
    BXD_GATHER  = 1'b0,
    BXD_SCATTER = 1'b1
  } bxd_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } bxd_state_e;

  // Pointer advance for one mask position: returns {read_inc, write_inc}.
  // Gather walks the source on every position and writes only on set bits;
  // scatter walks the result on every position and reads only on set bits.
  function automatic logic [1:0] bxd_ptr_inc(input bxd_op_e op, input logic sel);
    logic rd_inc;
    logic wr_inc;
    if (op == BXD_GATHER) begin
      rd_inc = 1'b1;
      wr_inc = sel;
    end else begin
      rd_inc = sel;
      wr_inc = 1'b1;
    end
    return {rd_inc, wr_inc};
  endfunction

endpackage

// File: rtl/bxd_ctrl.sv
module bxd_ctrl
  import bxd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic mask_nz,
  output logic load_en,
  output logic step_en,
  output logic busy,
  output logic done
);

  bxd_state_e state_q;
  logic       finish;

  assign busy    = (state_q == ST_RUN);
  assign load_en = start && (state_q == ST_IDLE);
  assign step_en = busy && mask_nz;
  assign finish  = busy && !mask_nz;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      done    <= 1'b0;
    end else begin
      done <= finish;
      case (state_q)
        ST_IDLE: if (load_en) state_q <= ST_RUN;
        ST_RUN:  if (finish)  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4
  finish_done_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !mask_nz) |=> (done && !busy));

endmodule

// File: rtl/bxd_path.sv
module bxd_path
  import bxd_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_en,
  input  logic         step_en,
  input  logic         op_in,
  input  logic [W-1:0] src_in,
  input  logic [W-1:0] mask_in,
  output logic [W-1:0] result,
  output logic         mask_nz
);

  localparam int IW = $clog2(W);
  localparam int PW = IW + 1;

  bxd_op_e       op_q;
  logic [W-1:0]  src_q;
  logic [W-1:0]  mask_q;
  logic [W-1:0]  res_q;
  logic [PW-1:0] rd_ptr;
  logic [PW-1:0] wr_ptr;
  logic [1:0]    inc;
  logic          sel;

  assign sel     = mask_q[0];
  assign inc     = bxd_ptr_inc(op_q, sel);
  assign mask_nz = |mask_q;
  assign result  = res_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= BXD_GATHER;
      src_q  <= '0;
      mask_q <= '0;
      res_q  <= '0;
      rd_ptr <= '0;
      wr_ptr <= '0;
    end else if (load_en) begin
      op_q   <= bxd_op_e'(op_in);
      src_q  <= src_in;
      mask_q <= mask_in;
      res_q  <= '0;
      rd_ptr <= '0;
      wr_ptr <= '0;
    end else if (step_en) begin
      mask_q <= mask_q >> 1;
      if (sel) res_q[wr_ptr[IW-1:0]] <= src_q[rd_ptr[IW-1:0]];
      rd_ptr <= rd_ptr + PW'(inc[1]);
      wr_ptr <= wr_ptr + PW'(inc[0]);
    end
  end

  // R6
  src_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> ($stable(src_q) && $stable(op_q)));

  // R4
  step_nz_chk: assert property (@(posedge clk) disable iff (rst)
    step_en |-> (mask_q != '0 && rd_ptr < PW'(W) && wr_ptr < PW'(W)));

  // R3
  pop_bound_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(res_q) <= int'(wr_ptr));

endmodule

// File: rtl/bxd_unit.sv
module bxd_unit
  import bxd_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         op,
  input  logic [W-1:0] src,
  input  logic [W-1:0] mask,
  output logic [W-1:0] result,
  output logic         done,
  output logic         busy
);

  logic load_en;
  logic step_en;
  logic mask_nz;

  bxd_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .mask_nz (mask_nz),
    .load_en (load_en),
    .step_en (step_en),
    .busy    (busy),
    .done    (done)
  );

  bxd_path #(.W(W)) u_path (
    .clk     (clk),
    .rst     (rst),
    .load_en (load_en),
    .step_en (step_en),
    .op_in   (op),
    .src_in  (src),
    .mask_in (mask),
    .result  (result),
    .mask_nz (mask_nz)
  );

  // R8
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && result == '0));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(result));

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

endmodule

// File: tb/sim_bxd_unit.sv
`timescale 1ns/1ps
module sim_bxd_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        op = 1'b0;
  logic [31:0] src = '0;
  logic [31:0] mask = '0;
  logic [31:0] result;
  logic        done;
  logic        busy;

  int checks = 0;
  int fails  = 0;
  logic [31:0] rng = 32'h1234_5678;

  always #10 clk = ~clk;

  bxd_unit #(.W(32)) u0 (
    .clk(clk), .rst(rst), .start(start), .op(op), .src(src), .mask(mask),
    .result(result), .done(done), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] x);
    logic [31:0] y = x;
    y = y ^ (y << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  // number of set mask bits strictly below position i
  function automatic int below(input logic [31:0] m, input int i);
    int c = 0;
    for (int j = 0; j < i; j++) c += int'(m[j]);
    return c;
  endfunction

  function automatic logic [31:0] model(input logic o, input logic [31:0] s, input logic [31:0] m);
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++)
      if (m[i]) begin
        if (!o) r[below(m, i)] = s[i];
        else    r[i] = s[below(m, i)];
      end
    return r;
  endfunction

  function automatic int lat(input logic [31:0] m);
    int h = -1;
    for (int i = 0; i < 32; i++) if (m[i]) h = i;
    return h + 2;
  endfunction

  task automatic run_op(input logic o, input logic [31:0] s, input logic [31:0] m, input bit intrude);
    logic [31:0] exp;
    logic [31:0] unw;
    int cyc;
    int pc;
    exp = model(o, s, m);
    pc = $countones(m);
    @(negedge clk);
    op = o; src = s; mask = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1 && result === 32'h0, "R8", result, 32'h0);
    cyc = 0;
    while (done !== 1'b1 && cyc < 60) begin
      if (intrude && cyc == 1) begin
        start = 1'b1; op = ~o; src = ~s; mask = ~m;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    if (m == 32'h0) begin
      chk(cyc == 1, "R5", 32'(cyc), 32'd1);
      chk(result === 32'h0, "R5", result, 32'h0);
    end else begin
      chk(cyc == lat(m), "R4", 32'(cyc), 32'(lat(m)));
    end
    if (intrude) chk(result === exp, "R6", result, exp);
    else if (!o) chk(result === exp, "R1", result, exp);
    else         chk(result === exp, "R2", result, exp);
    if (!o) unw = (pc >= 32) ? 32'h0 : (result >> pc);
    else    unw = result & ~m;
    chk(unw === 32'h0, "R3", unw, 32'h0);
    chk(busy === 1'b0, "R7", {31'h0, busy}, 32'h0);
    exp = result;
    src = ~src; mask = ~mask; op = ~op;
    @(negedge clk);
    chk(done === 1'b0 && result === exp, "R7", result, exp);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] dm [6];
    dm[0] = 32'h0000_0000; dm[1] = 32'hFFFF_FFFF; dm[2] = 32'h8000_0000;
    dm[3] = 32'h0000_0001; dm[4] = 32'hAAAA_AAAA; dm[5] = 32'h0000_FF00;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && result === 32'h0, "R9", result, 32'h0);
    rst = 1'b0;
    for (int o = 0; o < 2; o++)
      for (int i = 0; i < 6; i++) begin
        run_op(o[0], 32'hF0F0_A5C3, dm[i], 1'b0);
        run_op(o[0], 32'h5A3C_0FF1, dm[i], 1'b0);
      end
    for (int k = 0; k < 300; k++) begin
      logic [31:0] a, b, c;
      rng = nxt(rng); a = rng;
      rng = nxt(rng); b = rng;
      rng = nxt(rng); c = rng;
      run_op(k[0], a, (k % 3 == 0) ? (b & c) : b, 1'b0);
    end
    // ignored start while busy
    run_op(1'b0, 32'hDEAD_BEEF, 32'h8421_1248, 1'b1);
    run_op(1'b1, 32'h0000_1357, 32'hF000_00F0, 1'b1);
    // idle hold with changing inputs
    for (int k = 0; k < 8; k++) begin
      logic [31:0] held;
      held = result;
      rng = nxt(rng);
      src = rng; mask = ~rng; op = rng[0];
      @(negedge clk);
      chk(result === held && done === 1'b0, "R7", result, held);
    end
    // reset mid-run
    @(negedge clk);
    op = 1'b0; src = 32'hFFFF_FFFF; mask = 32'hFFFF_FFFF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && result === 32'h0, "R9", result, 32'h0);
    rst = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule